// File: doc/BRIEF.md
# Bus handshake timing adapter

This block is glue logic. It lets a peripheral bus master take part in a host bus. The peripheral uses an asynchronous handshake with an address strobe and an acknowledge. The host bus uses a transfer-start and transfer-acknowledge handshake. The adapter brings the peripheral's active-low address strobe onto the bus clock with a synchronizer chain and looks for a high-to-low transition. When it finds one, it pulls the transfer-start line low toward the host bus controller.

Every bus cycle has the same length, so the adapter needs no wait-state input from the bus controller. It counts a fixed number of bus clocks from the detection and then asserts the acknowledge back to the peripheral. The acknowledge is held until the peripheral lifts its address strobe. Transfer-start and acknowledge are then released together on one clock edge.

The transfer-start line is driven only while the peripheral owns the bus. At all other times its enable is low, so another master can drive the shared line. On write cycles the synchronized data strobe is qualified with the active cycle and signals that write data is valid.

Top module: `hsa_top`

## Requirements
- R1: While `rst` is high, every clock edge sets `ts_n_o`=1, `ack_n_o`=1, `ts_oe_o`=0 and `wvld_o`=0.
- R2: With ownership held, `ack_n_o` goes low on the 5th rising clock edge after `as_n_i` falls. This is 2 synchronizer edges, 1 detection edge and `ACK_CYCLES`=2 count edges.
- R3: `ts_n_o` goes low on the 3rd rising edge after `as_n_i` falls. It stays low until the edge on which `ack_n_o` returns high, and it rises on that same edge.
- R4: `ack_n_o` stays low while `as_n_i` stays low. It returns high on the 3rd rising edge after `as_n_i` rises.
- R5: Only a high-to-low transition of the synchronized strobe starts a cycle. A strobe that is already low, or that fell while the peripheral did not own the bus, starts nothing until it has been seen high again.
- R6: `ts_oe_o` equals `own_i` as sampled on the previous rising edge. While `ts_oe_o` is 0, `ts_n_o` is 1.
- R7: If `own_i` is low at a rising edge during a cycle, that edge returns the block to idle, with `ts_n_o`=1 and `ack_n_o`=1.
- R8: `wvld_o` is 1 after an edge at which `own_i` was high, the block is in a cycle (from detection until release), and the synchronized `ds_n_i` is 0. Otherwise `wvld_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| own_i | input | 1 | Peripheral currently owns the bus |
| as_n_i | input | 1 | Peripheral address strobe, active low, asynchronous |
| ds_n_i | input | 1 | Peripheral data strobe, active low, asynchronous |
| ts_n_o | output | 1 | Transfer-start toward the host bus controller, active low |
| ts_oe_o | output | 1 | Output enable for the transfer-start line |
| ack_n_o | output | 1 | Data-transfer acknowledge to the peripheral, active low |
| wvld_o | output | 1 | Write data valid during an active cycle |

## Verification
The bench counts the exact edge on which transfer-start and acknowledge fall after a strobe edge. A design with a missing synchronizer stage or a count that is off by one would answer a clock early or late. It holds the strobe low long after the acknowledge to show that no second cycle is started, and that the acknowledge does not drop on its own. It takes bus ownership away in the middle of a cycle and then returns it with the strobe still low. A design that did not abort would keep driving the shared line. A design that armed on level instead of edge would start a phantom cycle.

// File: rtl/hsa_pkg.sv
package hsa_pkg;
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_COUNT = 2'd1,
        PH_ACK   = 2'd2
    } phase_e;
endpackage

// File: rtl/hsa_sync.sv
module hsa_sync #(
    parameter int STAGES    = 2,
    parameter bit RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb chain_d = din;
        end else begin : g_many
            always_comb chain_d = {chain_q[STAGES-2:0], din};
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) chain_q <= {STAGES{RESET_VAL}};
        else     chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/hsa_fsm.sv
module hsa_fsm
    import hsa_pkg::*;
#(
    parameter int ACK_CYCLES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic own_i,
    input  logic as_s_i,
    input  logic ds_s_i,
    output logic ts_n_o,
    output logic ts_oe_o,
    output logic ack_n_o,
    output logic wvld_o
);
    localparam int CW = (ACK_CYCLES < 2) ? 1 : $clog2(ACK_CYCLES);

    typedef struct packed {
        phase_e        ph;
        logic [CW-1:0] cnt;
        logic          prev;
        logic          ts_n;
        logic          ack_n;
        logic          oe;
        logic          wv;
    } st_t;

    st_t s_d, s_q;
    logic fall;

    always_comb begin
        s_d      = s_q;
        s_d.prev = as_s_i;
        s_d.oe   = own_i;
        fall     = s_q.prev & ~as_s_i;
        case (s_q.ph)
            PH_IDLE: begin
                if (fall) begin
                    s_d.ph   = PH_COUNT;
                    s_d.cnt  = CW'(ACK_CYCLES - 1);
                    s_d.ts_n = 1'b0;
                end
            end
            PH_COUNT: begin
                if (s_q.cnt == '0) begin
                    s_d.ph    = PH_ACK;
                    s_d.ack_n = 1'b0;
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            PH_ACK: begin
                if (as_s_i) begin
                    s_d.ph    = PH_IDLE;
                    s_d.ack_n = 1'b1;
                    s_d.ts_n  = 1'b1;
                end
            end
            default: s_d.ph = PH_IDLE;
        endcase
        if (!own_i) begin
            s_d.ph    = PH_IDLE;
            s_d.cnt   = '0;
            s_d.ts_n  = 1'b1;
            s_d.ack_n = 1'b1;
        end
        s_d.wv = own_i && (s_d.ph != PH_IDLE) && !ds_s_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q.ph    <= PH_IDLE;
            s_q.cnt   <= '0;
            s_q.prev  <= 1'b1;
            s_q.ts_n  <= 1'b1;
            s_q.ack_n <= 1'b1;
            s_q.oe    <= 1'b0;
            s_q.wv    <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign ts_n_o  = s_q.ts_n;
    assign ts_oe_o = s_q.oe;
    assign ack_n_o = s_q.ack_n;
    assign wvld_o  = s_q.wv;

    // R1: reset forces inactive outputs
    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (ack_n_o && ts_n_o && !ts_oe_o && !wvld_o));

    // R2: acknowledge only falls after transfer-start was already low
    a_r2_ack_after_ts: assert property (@(posedge clk) disable iff (rst)
        $fell(ack_n_o) |-> $past(!ts_n_o));

    // R3: transfer-start released on the edge where acknowledge rises
    a_r3_ts_with_ack: assert property (@(posedge clk) disable iff (rst)
        $rose(ack_n_o) |-> ts_n_o);

    // R5: a new start never overlaps an acknowledge still held
    a_r5_no_overlap: assert property (@(posedge clk) disable iff (rst)
        $fell(ts_n_o) |-> $past(ack_n_o));

    // R6: enable follows ownership one clock later
    a_r6_oe_follows: assert property (@(posedge clk) disable iff (rst)
        own_i |=> ts_oe_o);

    // R7: lost ownership releases everything on the next edge
    a_r7_drop_release: assert property (@(posedge clk) disable iff (rst)
        !own_i |=> (ack_n_o && ts_n_o && !ts_oe_o && !wvld_o));
endmodule

// File: rtl/hsa_top.sv
module hsa_top #(
    parameter int SYNC_STAGES = 2,
    parameter int ACK_CYCLES  = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic own_i,
    input  logic as_n_i,
    input  logic ds_n_i,
    output logic ts_n_o,
    output logic ts_oe_o,
    output logic ack_n_o,
    output logic wvld_o
);
    logic as_s, ds_s;

    hsa_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_as_sync (
        .clk(clk), .rst(rst), .din(as_n_i), .dout(as_s)
    );

    hsa_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_ds_sync (
        .clk(clk), .rst(rst), .din(ds_n_i), .dout(ds_s)
    );

    hsa_fsm #(.ACK_CYCLES(ACK_CYCLES)) u_fsm (
        .clk(clk), .rst(rst), .own_i(own_i),
        .as_s_i(as_s), .ds_s_i(ds_s),
        .ts_n_o(ts_n_o), .ts_oe_o(ts_oe_o),
        .ack_n_o(ack_n_o), .wvld_o(wvld_o)
    );
endmodule

// File: tb/sim_hsa_top.sv
module sim_hsa_top;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic own_i = 1'b0;
    logic as_n_i = 1'b1;
    logic ds_n_i = 1'b1;
    logic ts_n_o, ts_oe_o, ack_n_o, wvld_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hsa_top u0 (
        .clk(clk), .rst(rst), .own_i(own_i), .as_n_i(as_n_i), .ds_n_i(ds_n_i),
        .ts_n_o(ts_n_o), .ts_oe_o(ts_oe_o), .ack_n_o(ack_n_o), .wvld_o(wvld_o)
    );

    // Behavioural reference: strobe delay lines plus a cycle tracker
    bit a_hist[$];
    bit d_hist[$];
    bit m_armed;
    int m_left;
    bit m_busy, m_ackd;
    bit e_ts, e_ack, e_oe, e_wv;

    initial begin
        a_hist = '{1, 1};
        d_hist = '{1, 1};
    end

    always @(posedge clk) begin
        bit a_now, d_now;
        cycles++;
        a_now = a_hist[0];
        d_now = d_hist[0];
        if (rst) begin
            a_hist = '{1, 1}; d_hist = '{1, 1};
            m_armed = 0; m_busy = 0; m_ackd = 0; m_left = 0;
            e_ts = 1; e_ack = 1; e_oe = 0; e_wv = 0;
        end else begin
            e_oe = own_i;
            if (!own_i) begin
                m_busy = 0; m_ackd = 0;
            end else if (!m_busy) begin
                if (m_armed && !a_now) begin
                    m_busy = 1; m_ackd = 0; m_left = 2;
                end
            end else if (!m_ackd) begin
                m_left--;
                if (m_left == 0) m_ackd = 1;
            end else if (a_now) begin
                m_busy = 0; m_ackd = 0;
            end
            m_armed = a_now;
            e_ts  = !m_busy;
            e_ack = !(m_busy && m_ackd);
            e_wv  = own_i && m_busy && !d_now;
            void'(a_hist.pop_front()); a_hist.push_back(as_n_i);
            void'(d_hist.pop_front()); d_hist.push_back(ds_n_i);
        end
    end

    always @(negedge clk) begin
        if (!done && cycles > 0) begin
            checks++;
            if (ts_n_o !== e_ts) begin errors++; $display("FAIL R3 ts_n_o actual %b expected %b", ts_n_o, e_ts); end
            checks++;
            if (ack_n_o !== e_ack) begin errors++; $display("FAIL R2 ack_n_o actual %b expected %b", ack_n_o, e_ack); end
            checks++;
            if (ts_oe_o !== e_oe) begin errors++; $display("FAIL R6 ts_oe_o actual %b expected %b", ts_oe_o, e_oe); end
            checks++;
            if (wvld_o !== e_wv) begin errors++; $display("FAIL R8 wvld_o actual %b expected %b", wvld_o, e_wv); end
        end
    end

    task automatic chk(input string tag, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual %b expected %b", tag, what, act, exp);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired, all requirements");
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        own_i = 1;
        edges(3);
        // R1: reset with ownership and strobe active
        as_n_i = 0;
        edges(2);
        chk("R1", "ts_n_o", ts_n_o, 1'b1);
        chk("R1", "ack_n_o", ack_n_o, 1'b1);
        chk("R1", "ts_oe_o", ts_oe_o, 1'b0);
        chk("R1", "wvld_o", wvld_o, 1'b0);
        as_n_i = 1;
        edges(3);
        rst = 0;
        edges(4);
        chk("R6", "ts_oe_o owned", ts_oe_o, 1'b1);

        // Write cycle: latency of start and acknowledge
        as_n_i = 0; ds_n_i = 0;
        edges(2);
        chk("R3", "ts_n_o before detection", ts_n_o, 1'b1);
        edges(1);
        chk("R3", "ts_n_o at 3rd edge", ts_n_o, 1'b0);
        edges(1);
        chk("R2", "ack_n_o at 4th edge", ack_n_o, 1'b1);
        edges(1);
        chk("R2", "ack_n_o at 5th edge", ack_n_o, 1'b0);
        chk("R8", "wvld_o during write", wvld_o, 1'b1);
        edges(6);
        chk("R4", "ack_n_o held", ack_n_o, 1'b0);
        chk("R5", "ts_n_o no restart", ts_n_o, 1'b0);
        ds_n_i = 1; as_n_i = 1;
        edges(2);
        chk("R4", "ack_n_o before release", ack_n_o, 1'b0);
        edges(1);
        chk("R4", "ack_n_o released", ack_n_o, 1'b1);
        chk("R3", "ts_n_o released with ack", ts_n_o, 1'b1);
        edges(4);

        // Read cycle with a short strobe pulse
        as_n_i = 0;
        edges(5);
        chk("R2", "ack_n_o read cycle", ack_n_o, 1'b0);
        chk("R8", "wvld_o read cycle", wvld_o, 1'b0);
        as_n_i = 1;
        edges(5);

        // R7: ownership lost mid-cycle
        as_n_i = 0;
        edges(4);
        own_i = 0;
        edges(1);
        chk("R7", "ts_n_o after drop", ts_n_o, 1'b1);
        chk("R7", "ack_n_o after drop", ack_n_o, 1'b1);
        chk("R6", "ts_oe_o after drop", ts_oe_o, 1'b0);
        edges(3);
        // R5: ownership returns with strobe still low
        own_i = 1;
        edges(8);
        chk("R5", "ts_n_o no level start", ts_n_o, 1'b1);
        chk("R5", "ack_n_o no level start", ack_n_o, 1'b1);
        as_n_i = 1;
        edges(4);

        // R5: strobe falls while not owner, then ownership returns
        own_i = 0;
        edges(2);
        as_n_i = 0;
        edges(5);
        own_i = 1;
        edges(8);
        chk("R5", "ts_n_o fall while unowned", ts_n_o, 1'b1);
        as_n_i = 1;
        edges(4);
        as_n_i = 0;
        edges(3);
        chk("R5", "ts_n_o rearmed start", ts_n_o, 1'b0);
        as_n_i = 1;
        edges(6);
        chk("R4", "ack_n_o idle at end", ack_n_o, 1'b1);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule